// File: doc/BRIEF.md
# Sleep-Level Clock Enable Controller

This block turns the low-power bits held in the processor status register into four clock enables: the main (CPU) clock, the sub-main peripheral clock, the oscillator, and the auxiliary clock. The block supports an active mode and five sleep levels. A status-register write port loads the bits. When the CPU accepts an interrupt, it pulses an acknowledge, and the block clears its copy of the bits at that point, so the handler runs with every clock on. When the handler ends, the CPU writes the saved bits back, and the block applies the earlier sleep level again.

While the CPU is halted, a pending request raises a wake request and forces the main clock on. A maskable request only counts while the global interrupt enable is set. A non-maskable request always counts. The wake request stays up until the CPU acknowledges entry. A configuration input states whether the oscillator drives the sub-main clock. That input decides whether sleep level 1 may stop the oscillator. All outputs are registered enables and carry one cycle of latency from the inputs.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset, all four clock enables are 1 and the wake request is 0 (active mode).
- R2: Low-power bits use bit0 = cpu-halt, bit1 = oscillator-stop, bit2 = clock-gate-0 and bit3 = clock-gate-1. Sleep level 0 is written as 4'b0001. One cycle after this write, the main clock is off and the sub-main, oscillator and auxiliary clocks are on.
- R3: Sleep level 1 is written as 4'b0101. In this level, the main clock is off and the auxiliary and sub-main clocks are on. The oscillator stays on only while the oscillator-feeds-sub-main input is 1.
- R4: Sleep level 2 is written as 4'b1001 and level 3 as 4'b1101. In both levels, only the auxiliary clock is on.
- R5: Sleep level 4 is written as 4'b1111. In this level, every clock enable is 0.
- R6: While the CPU is halted, a counted request raises the wake request and the main clock enable one cycle later. Other clock enables are left as decoded. An entry acknowledge clears the stored bits, which gives all clocks on and drops the wake request one cycle later.
- R7: The wake request stays at 1 after the request goes away, until an entry acknowledge.
- R8: A maskable request with the global enable at 0 does not wake a halted CPU.
- R9: Writing the saved bits back after a handler applies that sleep level again, including the main clock gate.
- R10: An entry acknowledge in the same cycle as a status-register write takes precedence, and the bits become 0.
- R11: Requests that arrive while the CPU is not halted do not raise the wake request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_load | input | 1 | Status-register low-power bits write strobe |
| sr_lp_bits | input | 4 | Low-power bits to load |
| gie | input | 1 | Global interrupt enable from the status register |
| irq_pending | input | NUM_SRC | Pending, individually enabled maskable requests |
| nmi_pending | input | 1 | Pending non-maskable request |
| irq_accept | input | 1 | CPU acknowledges interrupt entry |
| osc_feeds_sub | input | 1 | 1 when the oscillator drives the sub-main clock |
| mclk_en | output | 1 | Main/CPU clock enable |
| subclk_en | output | 1 | Sub-main clock enable |
| osc_en | output | 1 | Oscillator enable |
| auxclk_en | output | 1 | Auxiliary clock enable |
| wake_req | output | 1 | Main clock restart request |

## Verification
The bench builds the block with NUM_SRC = 3 and drives the maskable requests on a single source line. The other source lines stay at 0, so the OR of the request vector and the global-enable gating are both exercised. Changing the source count only widens that reduction, so the default value covers the same behaviour. The oscillator-feeds-sub-main input is toggled while the block sits at sleep level 1, which reaches both branches of that level's oscillator rule.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int LP_W       = 4;
  localparam int B_HALT     = 0;
  localparam int B_OSC_STOP = 1;
  localparam int B_GATE0    = 2;
  localparam int B_GATE1    = 3;

  typedef struct packed {
    logic gate1;
    logic gate0;
    logic osc_stop;
    logic halt;
  } lp_bits_t;

  typedef struct packed {
    logic mclk;
    logic sub;
    logic osc;
    logic aux;
  } clk_en_t;
endpackage

// File: rtl/lpm_sr_shadow.sv
module lpm_sr_shadow
  import lpm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [LP_W-1:0]    load_bits,
  input  logic               clear,
  output lp_bits_t           bits_q,
  output lp_bits_t           bits_next
);
  // Entry clear wins over a simultaneous load.
  always_comb begin
    bits_next = bits_q;
    if (clear)     bits_next = '0;
    else if (load) bits_next = lp_bits_t'(load_bits);
  end

  always_ff @(posedge clk) begin
    if (rst) bits_q <= '0;
    else     bits_q <= bits_next;
  end
endmodule

// File: rtl/lpm_wake_ctl.sv
module lpm_wake_ctl #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halted,
  input  logic               gie,
  input  logic [NUM_SRC-1:0] irq_pending,
  input  logic               nmi_pending,
  input  logic               accept,
  output logic               wake_q,
  output logic               wake_next
);
  logic maskable_any;
  logic counted;

  assign maskable_any = |irq_pending;
  assign counted      = (maskable_any & gie) | nmi_pending;

  always_comb begin
    wake_next = wake_q | (halted & counted);
    if (accept) wake_next = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) wake_q <= 1'b0;
    else     wake_q <= wake_next;
  end
endmodule

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
  import lpm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lp_bits_t bits,
  input  logic     wake,
  input  logic     osc_feeds_sub,
  output clk_en_t  en_q
);
  clk_en_t en_d;

  always_comb begin
    en_d.mclk = ~bits.halt | wake;
    en_d.sub  = ~bits.gate1;
    en_d.aux  = ~bits.osc_stop;
    en_d.osc  = ~(bits.gate1 | (bits.gate0 & ~osc_feeds_sub));
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '1;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sr_load,
  input  logic [3:0]         sr_lp_bits,
  input  logic               gie,
  input  logic [NUM_SRC-1:0] irq_pending,
  input  logic               nmi_pending,
  input  logic               irq_accept,
  input  logic               osc_feeds_sub,
  output logic               mclk_en,
  output logic               subclk_en,
  output logic               osc_en,
  output logic               auxclk_en,
  output logic               wake_req
);
  lp_bits_t bits_q, bits_next;
  logic     wake_next;
  clk_en_t  en_q;

  lpm_sr_shadow u_shadow (
    .clk(clk), .rst(rst), .load(sr_load), .load_bits(sr_lp_bits),
    .clear(irq_accept), .bits_q(bits_q), .bits_next(bits_next)
  );

  lpm_wake_ctl #(.NUM_SRC(NUM_SRC)) u_wake (
    .clk(clk), .rst(rst), .halted(bits_q.halt), .gie(gie),
    .irq_pending(irq_pending), .nmi_pending(nmi_pending),
    .accept(irq_accept), .wake_q(wake_req), .wake_next(wake_next)
  );

  lpm_gate_decode u_decode (
    .clk(clk), .rst(rst), .bits(bits_next), .wake(wake_next),
    .osc_feeds_sub(osc_feeds_sub), .en_q(en_q)
  );

  assign mclk_en   = en_q.mclk;
  assign subclk_en = en_q.sub;
  assign osc_en    = en_q.osc;
  assign auxclk_en = en_q.aux;
endmodule

// File: rtl/lpm_clk_ctrl_chk.sv
module lpm_clk_ctrl_chk #(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               gie,
  input logic [NUM_SRC-1:0] irq_pending,
  input logic               nmi_pending,
  input logic               irq_accept,
  input logic               mclk_en,
  input logic               subclk_en,
  input logic               osc_en,
  input logic               wake_req
);
  assert_accept_opens_R6: assert property (@(posedge clk) disable iff (rst)
    irq_accept |=> (mclk_en && !wake_req));

  assert_wake_held_R7: assert property (@(posedge clk) disable iff (rst)
    (wake_req && !irq_accept) |=> wake_req);

  assert_wake_runs_mclk_R6: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> mclk_en);

  assert_masked_no_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (!wake_req && !gie && !nmi_pending) |=> !wake_req);

  assert_sub_off_osc_off_R4: assert property (@(posedge clk) disable iff (rst)
    !subclk_en |-> !osc_en);
endmodule

bind lpm_clk_ctrl lpm_clk_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .gie(gie), .irq_pending(irq_pending),
  .nmi_pending(nmi_pending), .irq_accept(irq_accept), .mclk_en(mclk_en),
  .subclk_en(subclk_en), .osc_en(osc_en), .wake_req(wake_req)
);

// File: tb/lpm_clk_ctrl_tb.sv
module lpm_clk_ctrl_tb;
  localparam int NSRC = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sr_load = 1'b0;
  logic [3:0]      sr_lp_bits = '0;
  logic            gie = 1'b0;
  logic [NSRC-1:0] irq_pending = '0;
  logic            nmi_pending = 1'b0;
  logic            irq_accept = 1'b0;
  logic            osc_feeds_sub = 1'b1;
  logic            mclk_en, subclk_en, osc_en, auxclk_en, wake_req;

  int checks = 0;
  int fails  = 0;
  logic [4:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #5 clk = ~clk;

  lpm_clk_ctrl #(.NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rst(rst), .sr_load(sr_load), .sr_lp_bits(sr_lp_bits),
    .gie(gie), .irq_pending(irq_pending), .nmi_pending(nmi_pending),
    .irq_accept(irq_accept), .osc_feeds_sub(osc_feeds_sub),
    .mclk_en(mclk_en), .subclk_en(subclk_en), .osc_en(osc_en),
    .auxclk_en(auxclk_en), .wake_req(wake_req)
  );

  function automatic logic [4:0] outs();
    return {mclk_en, subclk_en, osc_en, auxclk_en, wake_req};
  endfunction

  // Driver: drive one cycle of inputs at the falling edge, queue expectation.
  // exp = {mclk, sub, osc, aux, wake}
  task automatic step(input logic ld, input logic [3:0] b, input logic g,
                      input logic p, input logic n, input logic acc,
                      input logic feed, input logic [4:0] exp, input string tag);
    @(negedge clk);
    sr_load = ld; sr_lp_bits = b; gie = g;
    irq_pending = {2'b00, p}; nmi_pending = n; irq_accept = acc;
    osc_feeds_sub = feed;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: one cycle after each driven cycle.
  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [4:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (outs() !== e) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b", t, outs(), e);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (outs() !== 5'b11110) begin
      fails++;
      $display("FAIL R1 actual=%b expected=%b", outs(), 5'b11110);
    end
    step(0, 4'b0000, 0, 0, 0, 0, 1, 5'b11110, "R1 idle");
    step(1, 4'b0001, 0, 0, 0, 0, 1, 5'b01110, "R2 level0");
    step(1, 4'b0101, 0, 0, 0, 0, 1, 5'b01110, "R3 level1 osc feeds sub");
    step(0, 4'b0000, 0, 0, 0, 0, 0, 5'b01010, "R3 level1 osc free");
    step(1, 4'b1001, 0, 0, 0, 0, 0, 5'b00010, "R4 level2");
    step(1, 4'b1101, 0, 0, 0, 0, 1, 5'b00010, "R4 level3");
    step(1, 4'b1111, 0, 0, 0, 0, 1, 5'b00000, "R5 level4");
    step(0, 4'b0000, 0, 1, 0, 0, 1, 5'b00000, "R8 masked request");
    step(0, 4'b0000, 0, 1, 0, 0, 1, 5'b00000, "R8 masked request held");
    step(0, 4'b0000, 0, 1, 1, 0, 1, 5'b10001, "R6 nmi wakes");
    step(0, 4'b0000, 0, 0, 0, 0, 1, 5'b10001, "R7 wake held");
    step(0, 4'b0000, 0, 0, 0, 1, 1, 5'b11110, "R6 accept clears");
    step(1, 4'b1111, 1, 0, 0, 0, 1, 5'b00000, "R9 restore level4");
    step(0, 4'b0000, 1, 1, 0, 0, 1, 5'b10001, "R6 maskable wakes");
    step(0, 4'b0000, 1, 1, 0, 1, 1, 5'b11110, "R6 accept second");
    step(1, 4'b0001, 1, 0, 0, 0, 1, 5'b01110, "R9 restore level0");
    step(1, 4'b1111, 1, 0, 0, 1, 1, 5'b11110, "R10 accept beats load");
    step(0, 4'b0000, 1, 1, 0, 0, 1, 5'b11110, "R11 active request");
    step(0, 4'b0000, 1, 0, 1, 0, 1, 5'b11110, "R11 active nmi");
    step(0, 4'b0000, 0, 0, 0, 0, 1, 5'b11110, "R11 idle after");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule